// File: doc/BRIEF.md
# Multi-Mode ADC Conversion Sequencer

This block drives a four-input, eight-bit analog-to-digital converter core through a start/done/result handshake. It decides which input the core converts next, files each returned sample into one of four result registers, and raises a sticky completion flag. The order of conversion, the register that receives each sample and how often the flag is raised all depend on a three-bit mode code and a four-bit input-select mask.

A sequence begins on one of three trigger sources: a software start pulse, a periodic timer tick, or a rising edge on an external line. Single-pass sequences end by themselves. Continuous sequences keep running until a stop request arrives, and the conversion already in flight is allowed to finish first. The mode code and mask are sampled when a sequence starts. The sub-mode of codes 001 and 010 follows from the number of mask bits that are set.

Top module: `adcseq_top`

## Requirements
- R1: No conversion starts when the input mask is all zero, or when the mode code {burst, continuous, scan} is 011, 101, 110 or 111.
- R2: Mode 001 with exactly one mask bit set performs one conversion of that input, writes the sample to result register N (where N is the input number) and sets the flag.
- R3: Mode 010 with exactly one mask bit set converts that input repeatedly and fills result registers 0, 1, 2, 3, then wraps to 0. The flag is set after every fourth conversion.
- R4: Mode 001 with two or more mask bits set converts every selected input once, from the lowest bit to the highest. Each sample goes to its own input's register, and the flag is set after the highest selected input.
- R5: Mode 100 scans the selected inputs in ascending order and restarts from the lowest selected input after each pass, filing samples by input number.
- R6: Mode 010 with two or more mask bits set alternates between the two lowest selected inputs A and B in the order A, B, A, B, writing registers 0, 1, 2, 3. The flag is set after each group of four.
- R7: Mode 000 performs exactly one conversion per trigger and sets the flag after each one. Successive triggers visit the selected inputs in ascending order and wrap from the highest back to the lowest. The pointer starts at input 0 after reset.
- R8: startSel selects the trigger: 0 = startReq pulse, 1 = timerTick, 2 = rising edge of extIn, 3 = no trigger. Trigger sources that are not selected are ignored.
- R9: A stop request lets the conversion in progress finish and write its result, then ends the sequence with no further start issued to the core.
- R10: convStart is a single-cycle pulse. convChan stays stable from that pulse until convDone, and no new start is issued while the core is busy.
- R11: The flag stays set until irqClr is asserted. If a set and a clear occur in the same cycle, the set wins.
- R12: After reset all result registers are zero, the flag is clear and convStart is low.
- R13: A trigger that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanMask | input | 4 | Input-select mask, bit N selects input N |
| modeBits | input | 3 | Mode code {burst, continuous, scan} |
| startSel | input | 2 | Trigger source select |
| startReq | input | 1 | Software start pulse |
| timerTick | input | 1 | Timer trigger pulse |
| extIn | input | 1 | External trigger line (rising edge) |
| stopReq | input | 1 | Stop request pulse |
| irqClr | input | 1 | Clears the completion flag |
| convStart | output | 1 | Start pulse to the converter core |
| convChan | output | 2 | Input number for the core |
| convDone | input | 1 | Core reports that the sample is ready |
| convData | input | 8 | Sample from the core, valid with convDone |
| results | output | 32 | Result registers, register N at bits 8N+7:8N |
| irqFlag | output | 1 | Sticky completion flag |

## Verification
The hardest situations to reach are the ones that depend on timing within a continuous run: wrapping the result slots, the flag staying clear before the fourth conversion, and a stop arriving between a launch and its done. The bench's core stub counts every launch it accepts. The stimulus waits until a chosen launch count is reached and then pulses the stop while that conversion is still pending, so each continuous run ends after an exact, known number of samples. Each sample carries its launch index, so a wrapped slot shows which conversion overwrote it.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int SEQ_CH = 4;
  localparam int SEQ_DW = 8;
  localparam int SEQ_CW = $clog2(SEQ_CH);

  typedef logic [SEQ_CW-1:0] chan_t;
  typedef logic [SEQ_CH-1:0] mask_t;

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT} seq_state_t;
  typedef enum logic [2:0] {K_STEP, K_FIX1, K_SCAN1, K_FIXC, K_DUAL, K_SCANC, K_NONE} seq_kind_t;

  typedef struct packed {
    logic  wrEn;
    chan_t wrIdx;
    logic  irqSet;
  } seq_strobe_t;

  function automatic int countSet(mask_t m);
    int n = 0;
    for (int i = 0; i < SEQ_CH; i++) n += int'(m[i]);
    return n;
  endfunction

  function automatic chan_t lowestSet(mask_t m);
    chan_t r = '0;
    for (int i = SEQ_CH - 1; i >= 0; i--) if (m[i]) r = chan_t'(i);
    return r;
  endfunction

  // returns {found, index} of the first set bit strictly above cur
  function automatic logic [SEQ_CW:0] nextAbove(mask_t m, chan_t cur);
    logic  f = 1'b0;
    chan_t r = '0;
    for (int i = 0; i < SEQ_CH; i++)
      if (!f && i > int'(cur) && m[i]) begin
        f = 1'b1;
        r = chan_t'(i);
      end
    return {f, r};
  endfunction

  // first set bit at or above from, wrapping around
  function automatic chan_t nextWrap(mask_t m, chan_t from);
    logic  f = 1'b0;
    chan_t r = '0;
    for (int i = 0; i < SEQ_CH; i++) begin
      int j;
      j = (int'(from) + i) % SEQ_CH;
      if (!f && m[j]) begin
        f = 1'b1;
        r = chan_t'(j);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mask_t       chanMask,
  input  logic [2:0]  modeBits,
  input  logic [1:0]  startSel,
  input  logic        startReq,
  input  logic        timerTick,
  input  logic        extIn,
  input  logic        stopReq,
  input  logic        convDone,
  output logic        convStart,
  output chan_t       convChan,
  output seq_strobe_t strobe
);
  seq_state_t state;
  seq_kind_t  kind, startKind;
  mask_t      maskLat;
  chan_t      curChan, slot, stepPtr, dualA, dualB, firstA, secondB, nxIdx;
  logic       stopPend, extPrev, trig, canStart, lastPass;
  logic [SEQ_CW:0] nxRaw, secRaw;

  // trigger source
  always_comb begin
    case (startSel)
      2'd0:    trig = startReq;
      2'd1:    trig = timerTick;
      2'd2:    trig = extIn & ~extPrev;
      default: trig = 1'b0;
    endcase
  end

  // sub-mode resolution from code and mask population
  always_comb begin
    case (modeBits)
      3'b000:  startKind = K_STEP;
      3'b001:  startKind = (countSet(chanMask) == 1) ? K_FIX1 : K_SCAN1;
      3'b010:  startKind = (countSet(chanMask) == 1) ? K_FIXC : K_DUAL;
      3'b100:  startKind = K_SCANC;
      default: startKind = K_NONE;
    endcase
  end

  assign canStart = trig && (chanMask != '0) && (startKind != K_NONE);
  assign firstA   = lowestSet(chanMask);
  assign secRaw   = nextAbove(chanMask, firstA);
  assign secondB  = secRaw[SEQ_CW-1:0];
  assign nxRaw    = nextAbove(maskLat, curChan);
  assign nxIdx    = nxRaw[SEQ_CW-1:0];
  assign lastPass = ~nxRaw[SEQ_CW];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      kind     <= K_NONE;
      maskLat  <= '0;
      curChan  <= '0;
      slot     <= '0;
      stepPtr  <= '0;
      dualA    <= '0;
      dualB    <= '0;
      stopPend <= 1'b0;
      extPrev  <= 1'b0;
    end else begin
      extPrev <= extIn;
      case (state)
        S_IDLE: begin
          stopPend <= 1'b0;
          if (canStart) begin
            kind    <= startKind;
            maskLat <= chanMask;
            slot    <= '0;
            dualA   <= firstA;
            dualB   <= secondB;
            curChan <= (startKind == K_STEP) ? nextWrap(chanMask, stepPtr) : firstA;
            state   <= S_LAUNCH;
          end
        end
        S_LAUNCH: begin
          if (stopReq) stopPend <= 1'b1;
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (stopReq) stopPend <= 1'b1;
          if (convDone) begin
            slot <= slot + 1'b1;
            case (kind)
              K_STEP: begin
                stepPtr <= curChan + 1'b1;
                state   <= S_IDLE;
              end
              K_SCAN1: begin
                if (lastPass) state <= S_IDLE;
                else begin
                  curChan <= nxIdx;
                  state   <= S_LAUNCH;
                end
              end
              K_SCANC: begin
                curChan <= lastPass ? lowestSet(maskLat) : nxIdx;
                state   <= S_LAUNCH;
              end
              K_FIXC:  state <= S_LAUNCH;
              K_DUAL: begin
                curChan <= slot[0] ? dualA : dualB;
                state   <= S_LAUNCH;
              end
              default: state <= S_IDLE;
            endcase
            if (stopPend || stopReq) state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign convStart = (state == S_LAUNCH);
  assign convChan  = curChan;

  always_comb begin
    strobe.wrEn   = (state == S_WAIT) && convDone;
    strobe.wrIdx  = (kind == K_FIXC || kind == K_DUAL) ? slot : curChan;
    case (kind)
      K_STEP, K_FIX1:   strobe.irqSet = strobe.wrEn;
      K_SCAN1, K_SCANC: strobe.irqSet = strobe.wrEn && lastPass;
      K_FIXC, K_DUAL:   strobe.irqSet = strobe.wrEn && (slot == chan_t'(SEQ_CH - 1));
      default:          strobe.irqSet = 1'b0;
    endcase
  end

  // R10
  launch_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
  // R10
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && !convDone) |=> $stable(convChan));
  // R1
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && chanMask == '0) |=> !convStart);
  // R9
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && convDone && (stopPend || stopReq)) |=> (state == S_IDLE && !convStart));
endmodule

// File: rtl/adcseq_data.sv
module adcseq_data
  import adcseq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  seq_strobe_t              strobe,
  input  logic [SEQ_DW-1:0]        wrData,
  input  logic                     irqClr,
  output logic [SEQ_CH*SEQ_DW-1:0] results,
  output logic                     irqFlag
);
  logic [SEQ_DW-1:0] resultReg [SEQ_CH];

  for (genvar g = 0; g < SEQ_CH; g++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rstN)                                           resultReg[g] <= '0;
      else if (strobe.wrEn && strobe.wrIdx == chan_t'(g))  resultReg[g] <= wrData;
    end
    assign results[g*SEQ_DW +: SEQ_DW] = resultReg[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              irqFlag <= 1'b0;
    else if (strobe.irqSet) irqFlag <= 1'b1;
    else if (irqClr)        irqFlag <= 1'b0;
  end

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> resultReg[$past(strobe.wrIdx)] == $past(wrData));
  // R11
  flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(strobe.irqSet));
  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [SEQ_CH-1:0]        chanMask,
  input  logic [2:0]               modeBits,
  input  logic [1:0]               startSel,
  input  logic                     startReq,
  input  logic                     timerTick,
  input  logic                     extIn,
  input  logic                     stopReq,
  input  logic                     irqClr,
  output logic                     convStart,
  output logic [SEQ_CW-1:0]        convChan,
  input  logic                     convDone,
  input  logic [SEQ_DW-1:0]        convData,
  output logic [SEQ_CH*SEQ_DW-1:0] results,
  output logic                     irqFlag
);
  seq_strobe_t strobe;

  adcseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chanMask(chanMask), .modeBits(modeBits),
    .startSel(startSel), .startReq(startReq), .timerTick(timerTick),
    .extIn(extIn), .stopReq(stopReq), .convDone(convDone),
    .convStart(convStart), .convChan(convChan), .strobe(strobe)
  );

  adcseq_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(convData),
    .irqClr(irqClr), .results(results), .irqFlag(irqFlag)
  );
endmodule

// File: tb/sim_adcseq_top.sv
module sim_adcseq_top;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] chanMask = '0;
  logic [2:0] modeBits = '0;
  logic [1:0] startSel = '0;
  logic       startReq = 0, timerTick = 0, extIn = 0, stopReq = 0, irqClr = 0;
  logic       convStart, convDone;
  logic [1:0] convChan;
  logic [7:0] convData;
  logic [31:0] results;
  logic       irqFlag;

  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  adcseq_top u0 (
    .clk(clk), .rstN(rstN), .chanMask(chanMask), .modeBits(modeBits),
    .startSel(startSel), .startReq(startReq), .timerTick(timerTick),
    .extIn(extIn), .stopReq(stopReq), .irqClr(irqClr),
    .convStart(convStart), .convChan(convChan), .convDone(convDone),
    .convData(convData), .results(results), .irqFlag(irqFlag)
  );

  // behavioural converter core stub with a launch log
  int         startCount = 0;
  int         hsErr = 0;
  logic [1:0] logChan [256];
  logic [7:0] logData [256];
  logic       stubBusy = 0;
  int         stubCnt = 0;
  logic [1:0] stubChan = '0;
  logic [7:0] stubVal = '0;
  logic       prevStart = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      convDone <= 1'b0;
      convData <= '0;
      stubBusy <= 1'b0;
      prevStart <= 1'b0;
    end else begin
      convDone  <= 1'b0;
      prevStart <= convStart;
      if (stubBusy) begin
        if (convChan != stubChan) hsErr <= hsErr + 1;
        if (stubCnt == 0) begin
          convDone <= 1'b1;
          convData <= stubVal;
          stubBusy <= 1'b0;
        end else stubCnt <= stubCnt - 1;
      end
      if (convStart) begin
        if (prevStart || stubBusy) hsErr <= hsErr + 1;
        stubBusy <= 1'b1;
        stubCnt  <= LAT;
        stubChan <= convChan;
        stubVal  <= {convChan, 6'(startCount)};
        logChan[startCount] <= convChan;
        logData[startCount] <= {convChan, 6'(startCount)};
        startCount <= startCount + 1;
      end
    end
  end

  // watchdog
  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] res(input int i);
    return results[i*8 +: 8];
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic clearIrq();
    pulse(irqClr);
  endtask

  task automatic waitStarts(input int n);
    int t = 0;
    while (startCount < n && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic setup(input logic [3:0] m, input logic [2:0] md, input logic [1:0] ss);
    @(negedge clk);
    chanMask = m; modeBits = md; startSel = ss;
  endtask

  // R12
  task automatic tReset();
    cyc(1);
    check(results == '0, "R12 results", int'(results), 0);
    check(irqFlag == 1'b0, "R12 flag", int'(irqFlag), 0);
    check(convStart == 1'b0, "R12 convStart", int'(convStart), 0);
  endtask

  // R1
  task automatic tReject();
    int b;
    b = startCount;
    setup(4'b0000, 3'b001, 2'd0); pulse(startReq); cyc(20);
    check(startCount == b, "R1 empty mask", startCount - b, 0);
    setup(4'b0011, 3'b011, 2'd0); pulse(startReq); cyc(20);
    check(startCount == b, "R1 code 011", startCount - b, 0);
    setup(4'b0011, 3'b110, 2'd0); pulse(startReq); cyc(20);
    check(startCount == b, "R1 code 110", startCount - b, 0);
  endtask

  // R7 single step from reset pointer
  task automatic tStep();
    int b;
    b = startCount;
    setup(4'b1010, 3'b000, 2'd0);
    pulse(startReq); cyc(20);
    check(startCount == b + 1, "R7 one per trigger", startCount - b, 1);
    check(logChan[b] == 2'd1, "R7 first chan", int'(logChan[b]), 1);
    check(irqFlag, "R7 flag 1", int'(irqFlag), 1);
    check(res(1) == logData[b], "R7 reg1", int'(res(1)), int'(logData[b]));
    clearIrq();
    pulse(startReq); cyc(20);
    check(logChan[b+1] == 2'd3, "R7 second chan", int'(logChan[b+1]), 3);
    check(irqFlag, "R7 flag 2", int'(irqFlag), 1);
    clearIrq();
    pulse(startReq); cyc(20);
    check(startCount == b + 3, "R7 count", startCount - b, 3);
    check(logChan[b+2] == 2'd1, "R7 wrap chan", int'(logChan[b+2]), 1);
    clearIrq();
  endtask

  // R2 and R11
  task automatic tFixedSingle();
    int b;
    b = startCount;
    setup(4'b0100, 3'b001, 2'd0); pulse(startReq); cyc(25);
    check(startCount == b + 1, "R2 single conv", startCount - b, 1);
    check(logChan[b] == 2'd2, "R2 chan", int'(logChan[b]), 2);
    check(res(2) == logData[b], "R2 reg2", int'(res(2)), int'(logData[b]));
    check(irqFlag, "R2 flag", int'(irqFlag), 1);
    cyc(30);
    check(irqFlag, "R11 sticky", int'(irqFlag), 1);
    clearIrq(); cyc(1);
    check(!irqFlag, "R11 cleared", int'(irqFlag), 0);
  endtask

  // R4 and R13
  task automatic tScanSingle();
    int b;
    logic [7:0] keep2;
    b = startCount;
    keep2 = res(2);
    setup(4'b1011, 3'b001, 2'd0); pulse(startReq);
    cyc(3);
    check(!irqFlag, "R4 flag not early", int'(irqFlag), 0);
    pulse(startReq);
    cyc(40);
    check(startCount == b + 3, "R13 retrigger ignored", startCount - b, 3);
    check(logChan[b] == 0 && logChan[b+1] == 1 && logChan[b+2] == 3, "R4 order",
          {logChan[b], logChan[b+1], logChan[b+2]}, 6'b000111);
    check(res(0) == logData[b], "R4 reg0", int'(res(0)), int'(logData[b]));
    check(res(1) == logData[b+1], "R4 reg1", int'(res(1)), int'(logData[b+1]));
    check(res(3) == logData[b+2], "R4 reg3", int'(res(3)), int'(logData[b+2]));
    check(res(2) == keep2, "R4 reg2 untouched", int'(res(2)), int'(keep2));
    check(irqFlag, "R4 flag", int'(irqFlag), 1);
    clearIrq();
  endtask

  // R5 and R9
  task automatic tScanCont();
    int b;
    b = startCount;
    setup(4'b0110, 3'b100, 2'd0); pulse(startReq);
    waitStarts(b + 5); pulse(stopReq); cyc(40);
    check(startCount == b + 5, "R9 stop after current", startCount - b, 5);
    check(logChan[b+2] == 1 && logChan[b+3] == 2 && logChan[b+4] == 1, "R5 restart",
          {logChan[b+2], logChan[b+3], logChan[b+4]}, 6'b011001);
    check(res(1) == logData[b+4], "R5 reg1 last", int'(res(1)), int'(logData[b+4]));
    check(res(2) == logData[b+3], "R5 reg2 last", int'(res(2)), int'(logData[b+3]));
    check(irqFlag, "R5 flag after pass", int'(irqFlag), 1);
    clearIrq();
  endtask

  // R3
  task automatic tFixCont();
    int b;
    b = startCount;
    setup(4'b1000, 3'b010, 2'd0); pulse(startReq);
    waitStarts(b + 3); pulse(stopReq); cyc(40);
    check(startCount == b + 3, "R3 three convs", startCount - b, 3);
    check(!irqFlag, "R3 no flag before fourth", int'(irqFlag), 0);
    check(res(2) == logData[b+2], "R3 slot2", int'(res(2)), int'(logData[b+2]));
    b = startCount;
    pulse(startReq);
    waitStarts(b + 6); pulse(stopReq); cyc(40);
    check(startCount == b + 6, "R3 six convs", startCount - b, 6);
    check(irqFlag, "R3 flag at fourth", int'(irqFlag), 1);
    check(res(0) == logData[b+4], "R3 wrap slot0", int'(res(0)), int'(logData[b+4]));
    check(res(1) == logData[b+5], "R3 wrap slot1", int'(res(1)), int'(logData[b+5]));
    check(res(2) == logData[b+2], "R3 slot2 kept", int'(res(2)), int'(logData[b+2]));
    check(res(3) == logData[b+3], "R3 slot3", int'(res(3)), int'(logData[b+3]));
    clearIrq();
  endtask

  // R6
  task automatic tDual();
    int b;
    b = startCount;
    setup(4'b1101, 3'b010, 2'd0); pulse(startReq);
    waitStarts(b + 4); pulse(stopReq); cyc(40);
    check(startCount == b + 4, "R6 count", startCount - b, 4);
    check(logChan[b] == 0 && logChan[b+1] == 2 && logChan[b+2] == 0 && logChan[b+3] == 2,
          "R6 order", {logChan[b], logChan[b+1], logChan[b+2], logChan[b+3]}, 8'b00100010);
    for (int i = 0; i < 4; i++)
      check(res(i) == logData[b+i], "R6 slot", int'(res(i)), int'(logData[b+i]));
    check(irqFlag, "R6 flag", int'(irqFlag), 1);
    clearIrq();
  endtask

  // R8
  task automatic tStartSel();
    int b;
    b = startCount;
    setup(4'b0001, 3'b001, 2'd1);
    pulse(startReq); cyc(20);
    check(startCount == b, "R8 timer ignores startReq", startCount - b, 0);
    pulse(timerTick); cyc(20);
    check(startCount == b + 1, "R8 timer tick", startCount - b, 1);
    setup(4'b0001, 3'b001, 2'd2);
    pulse(timerTick); cyc(20);
    check(startCount == b + 1, "R8 edge ignores tick", startCount - b, 1);
    @(negedge clk); extIn = 1'b1; cyc(20);
    check(startCount == b + 2, "R8 rising edge", startCount - b, 2);
    @(negedge clk); extIn = 1'b0; cyc(20);
    check(startCount == b + 2, "R8 falling edge ignored", startCount - b, 2);
    setup(4'b0001, 3'b001, 2'd3);
    pulse(startReq); pulse(timerTick);
    @(negedge clk); extIn = 1'b1; cyc(20); extIn = 1'b0;
    check(startCount == b + 2, "R8 no source", startCount - b, 2);
    clearIrq();
  endtask

  initial begin
    cyc(4);
    rstN = 1'b1;
    tReset();
    tStep();
    tReject();
    tFixedSingle();
    tScanSingle();
    tScanCont();
    tFixCont();
    tDual();
    tStartSel();
    // R10
    check(hsErr == 0, "R10 handshake", hsErr, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule